// File: doc/BRIEF.md
# Clock Regenerator Edge Resampler

This block runs on a fast clock that an upstream loop has already locked to a slower input clock, at a whole power-of-two multiple of it. It samples the raw input clock in the fast domain and rebuilds a clean copy. Every output transition falls on a rising edge of the fast clock. The output period is set only by the input rising edges, so a poor input duty cycle or jitter on the falling edges cannot change it.

A range code and a ratio code describe the configuration. The ratio code gives the fast-to-input ratio as 2^code. The output is offered only in the two lower output ranges, and never at a 1:1 ratio. A qualifier raises the valid flag once the input has shown a full period of the programmed length. It drops the flag when the input stops matching that length. The regenerated clock is forced low whenever the flag is low.

Top module: `clkregen_resampler`

## Requirements
- R1: While reset is asserted, and after reset while enable is low, both regen_clk and regen_valid are 0.
- R2: With regen_valid high, regen_clk after fast edge k equals the level of clk_in sampled at fast edge k-SYNC_STAGES (2 by default). This fixed latency is the same for rising and falling input edges.
- R3: While the input period equals the programmed ratio 2^ratio_code, regen_valid stays high. Each regen_clk period is then exactly 2^ratio_code fast cycles, for any input high time between 30% and 70% of the period, including high times that change from period to period.
- R4: The regen_clk high time in fast cycles equals the number of fast rising edges at which clk_in was sampled high within that input period. The falling edge is therefore quantized to the fast clock.
- R5: When the input falling edge alternates between two fast-clock slots, the regen_clk high time alternates between the two matching whole-cycle values.
- R6: After enable rises, regen_valid rises only at a detected input rising edge that comes exactly 2^ratio_code fast cycles after the previous detected one. This is no earlier than one full period and no later than 2*2^ratio_code+4 cycles after enable. regen_clk rises on the same edge. regen_clk is 0 whenever regen_valid is 0.
- R7: regen_valid stays 0 when range_sel is 2'b00 or 2'b01. The same holds when ratio_code is 0 (a 1:1 ratio) or greater than MAX_LOG2. Valid configurations are range_sel 2'b10 or 2'b11 with ratio_code from 1 to MAX_LOG2.
- R8: When a detected input rising edge arrives with a spacing other than 2^ratio_code, regen_valid falls on that edge. It also falls when 2^ratio_code cycles pass with no detected rising edge. Lock comes back after the next correctly spaced pair of rising edges.
- R9: Taking enable low clears regen_valid and regen_clk on the next fast edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast multiplied clock, locked to clk_in |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in | input | 1 | Raw input clock to be regenerated |
| range_sel | input | 2 | Output range code; only 2'b10 and 2'b11 allow output |
| ratio_code | input | $clog2(MAX_LOG2+1) (3) | Fast-to-input ratio as a power of two |
| enable | input | 1 | Enables qualification and output |
| regen_clk | output | 1 | Regenerated clock, transitions on fast rising edges |
| regen_valid | output | 1 | Output qualified as a clean copy of the input |

## Verification
The bench builds the block with its defaults: SYNC_STAGES=2 and MAX_LOG2=4. This puts every legal ratio (2, 4, 8 and 16) within reach of a full sweep. At each ratio, every whole-cycle high time from 30% to 70% is run in turn, along with an alternating falling-edge pattern and a random per-period high time. Expected periods, high times and the two-cycle delayed input image are worked out arithmetically from the generated stimulus. Every illegal range and ratio code is swept against a matching input. A period change and a stalled input exercise the loss and reacquisition of lock.

// File: rtl/clkregen_pkg.sv
package clkregen_pkg;

   typedef enum logic [1:0] {
      RANGE_TOP  = 2'b00,
      RANGE_HIGH = 2'b01,
      RANGE_MID  = 2'b10,
      RANGE_LOW  = 2'b11
   } range_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_s;

endpackage

// File: rtl/clkregen_sync.sv
module clkregen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkregen_edge.sv
module clkregen_edge
   import clkregen_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lvl,
   output edge_s ev
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign ev.rise = lvl & ~prev_q;
   assign ev.fall = ~lvl & prev_q;
endmodule

// File: rtl/clkregen_qual.sv
module clkregen_qual
   import clkregen_pkg::*;
#(
   parameter int MAX_LOG2 = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               enable,
   input  logic [1:0]                         range_sel,
   input  logic [$clog2(MAX_LOG2+1)-1:0]      ratio_code,
   input  logic                               rise,
   output logic                               valid_d,
   output logic                               valid_q
);
   localparam int CODE_W = $clog2(MAX_LOG2 + 1);
   localparam int CNT_W  = MAX_LOG2 + 2;

   logic [CNT_W-1:0] gap_q;
   logic [CNT_W-1:0] ratio_v;
   logic             seen_q;
   logic             range_ok, code_ok, clr;

   assign ratio_v  = CNT_W'(1) << ratio_code;
   assign range_ok = (range_e'(range_sel) == RANGE_MID) || (range_e'(range_sel) == RANGE_LOW);
   assign code_ok  = (ratio_code != '0) && (ratio_code <= CODE_W'(MAX_LOG2));
   assign clr      = !enable || !range_ok || !code_ok;

   always_comb begin
      if (clr)                  valid_d = 1'b0;
      else if (rise)            valid_d = seen_q && (gap_q == ratio_v);
      else if (gap_q >= ratio_v) valid_d = 1'b0;
      else                      valid_d = valid_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q   <= '0;
         seen_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= valid_d;
         if (clr)       seen_q <= 1'b0;
         else if (rise) seen_q <= 1'b1;
         if (rise)              gap_q <= CNT_W'(1);
         else if (gap_q != '1)  gap_q <= gap_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/clkregen_resampler.sv
module clkregen_resampler
   import clkregen_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_LOG2    = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clk_in,
   input  logic [1:0]                    range_sel,
   input  logic [$clog2(MAX_LOG2+1)-1:0] ratio_code,
   input  logic                          enable,
   output logic                          regen_clk,
   output logic                          regen_valid
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkregen_resampler: SYNC_STAGES must be at least 2");
      end
      if (MAX_LOG2 < 1) begin : g_bad_ratio
         $error("clkregen_resampler: MAX_LOG2 must be at least 1");
      end
   endgenerate

   logic  in_sync;
   edge_s ev;
   logic  valid_d;
   logic  regen_q;

   clkregen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (clk_in),
      .q     (in_sync)
   );

   clkregen_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (in_sync),
      .ev    (ev)
   );

   clkregen_qual #(.MAX_LOG2(MAX_LOG2)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .range_sel  (range_sel),
      .ratio_code (ratio_code),
      .rise       (ev.rise),
      .valid_d    (valid_d),
      .valid_q    (regen_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regen_q <= 1'b0;
      else if (!valid_d) regen_q <= 1'b0;
      else if (ev.rise)  regen_q <= 1'b1;
      else if (ev.fall)  regen_q <= 1'b0;
   end

   assign regen_clk = regen_q;
endmodule

// File: rtl/clkregen_checker.sv
module clkregen_checker #(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_LOG2    = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          clk_in,
   input logic [1:0]                    range_sel,
   input logic [$clog2(MAX_LOG2+1)-1:0] ratio_code,
   input logic                          enable,
   input logic                          regen_clk,
   input logic                          regen_valid
);
   localparam int CODE_W = $clog2(MAX_LOG2 + 1);
   localparam int CNT_W  = MAX_LOG2 + 2;

   logic             prev_q;
   logic [CNT_W-1:0] gap_q;
   logic [CNT_W-1:0] ratio_v;
   logic             out_rise;

   assign ratio_v  = CNT_W'(1) << ratio_code;
   assign out_rise = regen_clk && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         gap_q  <= '0;
      end else begin
         prev_q <= regen_clk;
         if (out_rise)          gap_q <= CNT_W'(1);
         else if (gap_q != '1)  gap_q <= gap_q + CNT_W'(1);
      end
   end

   AST_RISE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(regen_clk) |-> ($past(clk_in, SYNC_STAGES+1) && !$past(clk_in, SYNC_STAGES+2))); // R2

   AST_FALL_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(regen_clk) && regen_valid) |-> (!$past(clk_in, SYNC_STAGES+1) && $past(clk_in, SYNC_STAGES+2))); // R4

   AST_PERIOD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (out_rise && $past(regen_valid)) |-> (gap_q == ratio_v)); // R3

   AST_LOCK_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(regen_valid) |-> $rose(regen_clk)); // R6

   AST_LOW_WHILE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !regen_valid |-> !regen_clk); // R6

   AST_BAD_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
      (!range_sel[1] || ratio_code == '0 || ratio_code > CODE_W'(MAX_LOG2)) |=> !regen_valid); // R7

   AST_MISSING_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_q >= ratio_v && !out_rise) |-> !regen_valid); // R8

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!regen_valid && !regen_clk)); // R9

endmodule

bind clkregen_resampler clkregen_checker #(
   .SYNC_STAGES (SYNC_STAGES),
   .MAX_LOG2    (MAX_LOG2)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clk_in      (clk_in),
   .range_sel   (range_sel),
   .ratio_code  (ratio_code),
   .enable      (enable),
   .regen_clk   (regen_clk),
   .regen_valid (regen_valid)
);

// File: tb/sim_clkregen_resampler.sv
module sim_clkregen_resampler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_in = 1'b0;
   logic [1:0] range_sel = 2'b10;
   logic [2:0] ratio_code = 3'd3;
   logic       enable = 1'b0;
   logic       regen_clk;
   logic       regen_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // generator state: mode 0 fixed, 1 alternating, 2 random
   int gen_ratio = 8;
   int gen_high  = 4;
   int gen_mode  = 0;
   int gen_lo    = 1;
   int gen_hi    = 1;
   bit gen_stop  = 0;
   int phase     = 0;
   int cur_high  = 4;
   bit alt_sel   = 0;
   bit mon_en    = 0;

   always #5 clk = ~clk;

   clkregen_resampler u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .clk_in      (clk_in),
      .range_sel   (range_sel),
      .ratio_code  (ratio_code),
      .enable      (enable),
      .regen_clk   (regen_clk),
      .regen_valid (regen_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (gen_stop) clk_in = 1'b0;
      else begin
         if (phase == 0) begin
            case (gen_mode)
               0: cur_high = gen_high;
               1: begin cur_high = alt_sel ? gen_high + 1 : gen_high; alt_sel = ~alt_sel; end
               default: cur_high = $urandom_range(gen_hi, gen_lo);
            endcase
         end
         clk_in = (phase < cur_high);
         phase = (phase + 1 >= gen_ratio) ? 0 : phase + 1;
      end
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   // monitor, sampled 2 ns after each fast rising edge
   bit h1 = 0, h2 = 0, c_prev = 0, v_prev = 0, have_rise = 0;
   int gap = 0, hi_cnt = 0, last_high = -1;
   always @(posedge clk) begin
      #2;
      gap++;
      if (mon_en) begin
         chk(regen_valid == 1'b1, "R3 valid held", regen_valid, 1);
         if (regen_valid && v_prev) chk(regen_clk == h2, "R2 delayed image", regen_clk, h2);
         if (regen_clk && !c_prev) begin
            if (have_rise) chk(gap == gen_ratio, "R3 period", gap, gen_ratio);
            have_rise = 1;
         end
         if (!regen_clk && c_prev && have_rise) begin
            if (gen_mode == 0) chk(hi_cnt == gen_high, "R4 high time", hi_cnt, gen_high);
            else if (gen_mode == 1) begin
               chk(hi_cnt == gen_high || hi_cnt == gen_high + 1, "R5 high value", hi_cnt, gen_high);
               if (last_high >= 0) chk(hi_cnt != last_high, "R5 alternation", hi_cnt, last_high);
               last_high = hi_cnt;
            end
         end
      end else begin
         have_rise = 0;
         last_high = -1;
      end
      if (regen_clk && !c_prev) begin gap = 0; hi_cnt = 1; end
      else if (regen_clk) hi_cnt++;
      h2 = h1; h1 = clk_in; c_prev = regen_clk; v_prev = regen_valid;
   end

   task automatic run(input int code, input int rng, input int mode, input int high, input int periods);
      int r, waited;
      r = 1 << code;
      enable = 0;
      steps(3);
      ratio_code = 3'(code); range_sel = 2'(rng);
      gen_ratio = r; gen_mode = mode; gen_high = high; phase = 0; alt_sel = 0; gen_stop = 0;
      enable = 1;
      waited = 0;
      while (!regen_valid && waited < 2 * r + 12) begin step(); waited++; end
      chk(regen_valid == 1'b1, "R6 lock reached", regen_valid, 1);
      chk(waited >= r && waited <= 2 * r + 4, "R6 lock time", waited, r);
      steps(r);
      mon_en = 1;
      steps(periods * r);
      mon_en = 0;
      enable = 0;
      step();
      chk(!regen_valid && !regen_clk, "R9 disable", {regen_valid, regen_clk}, 0);
   endtask

   task automatic bad(input int rng, input int code, input int r);
      int bad_cnt;
      enable = 0;
      steps(2);
      range_sel = 2'(rng); ratio_code = 3'(code);
      gen_ratio = r; gen_mode = 0; gen_high = r / 2; phase = 0; gen_stop = 0;
      enable = 1;
      bad_cnt = 0;
      for (int i = 0; i < 6 * r + 10; i++) begin
         step();
         if (regen_valid || regen_clk) bad_cnt++;
      end
      chk(bad_cnt == 0, "R7 illegal config", bad_cnt, 0);
      enable = 0;
   endtask

   initial begin
      #(10 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int lo, hi, waited;
      steps(5);
      chk(!regen_clk && !regen_valid, "R1 in reset", {regen_clk, regen_valid}, 0);
      rst_n = 1;
      steps(40);
      chk(!regen_clk && !regen_valid, "R1 enable low", {regen_clk, regen_valid}, 0);

      for (int code = 1; code <= 4; code++) begin
         int r;
         r = 1 << code;
         lo = (3 * r + 9) / 10; if (lo < 1) lo = 1;
         hi = (7 * r) / 10;     if (hi < lo) hi = lo;
         for (int h = lo; h <= hi; h++) run(code, 2 + (code % 2), 0, h, 6);
         if (r >= 4) run(code, 2 + ((code + 1) % 2), 1, lo, 8);
         gen_lo = lo; gen_hi = hi;
         run(code, 2, 2, 0, 20);
      end

      bad(0, 3, 8);
      bad(1, 3, 8);
      bad(2, 0, 2);
      bad(3, 5, 32);
      bad(2, 6, 8);
      bad(3, 7, 8);

      // R8: period change drops lock, correct period relocks, stall drops lock
      enable = 0; steps(2);
      range_sel = 2'b11; ratio_code = 3'd3;
      gen_ratio = 8; gen_mode = 0; gen_high = 4; phase = 0; gen_stop = 0;
      enable = 1;
      steps(30);
      chk(regen_valid == 1'b1, "R8 initial lock", regen_valid, 1);
      gen_ratio = 4; gen_high = 2; phase = 0;
      steps(40);
      chk(!regen_valid && !regen_clk, "R8 wrong period", {regen_valid, regen_clk}, 0);
      gen_ratio = 8; gen_high = 4; phase = 0;
      waited = 0;
      while (!regen_valid && waited < 40) begin step(); waited++; end
      chk(regen_valid == 1'b1, "R8 relock", regen_valid, 1);
      gen_stop = 1;
      steps(8 + 6);
      chk(!regen_valid && !regen_clk, "R8 stalled input", {regen_valid, regen_clk}, 0);
      enable = 0;
      steps(4);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule